// File: doc/BRIEF.md
# Programmable Peripheral Clock Generator

This block produces a gated peripheral clock, modelled as single-cycle clock-enable pulses in one synchronous clock domain. Three reference tick inputs (I/O, CPU and memory reference) stand in for reference clocks. A control register chooses one of them, divides its ticks by a first programmable divider and then by a cascaded second divider, and gates the result onto one or two pulse outputs. Software reaches the block through a plain register port: a write strobe with a byte address and write data, and a combinational read path on the same address.

Build-time parameters select the variant. The default has two cascaded dividers and two independent output gates in the control register. The fabric-style variant holds its single gate in a separate register eight bytes above the control register, with a set bit meaning "stopped". The single-divider variant drops the second divider and gates directly after the first one. Divider and source changes are held back until the current divided period ends, so the output never shows a shortened or stretched period.

Top module: `periph_clk_gen`

## Requirements
- R1: After reset the control register reads 0x00100100 in the two-divider variant and 0x00000100 in the single-divider variant (I/O source, both dividers 1, gates off). The fabric gate register reads 1, and neither output pulses.
- R2: Control bits 5:4 pick the source. Codes 0 and 1 both pick the I/O reference, code 2 the CPU reference and code 3 the memory reference.
- R3: Control bits 13:8 hold the first divider N, which is one-based: N source ticks make one first-stage period. A value of 0 acts as 1.
- R4: Control bits 25:20 hold the second divider M, which counts first-stage periods and follows the same rules. One output pulse comes every N*M source ticks (zeros counted as 1).
- R5: In the dual-output variant, control bit 0 gates output 0 and bit 1 gates output 1 (1 = running). Both outputs carry the same divided pulses.
- R6: In the fabric variant, gating sits in bit 0 of the register at control offset + 8, where 1 stops the output. Control bits 1:0 are not stored and have no effect, and output 1 stays low.
- R7: In the single-divider variant, control bits 25:20 are not stored (they read 0) and do not change the pulse rate.
- R8: A new source or divider value takes effect only at the end of the current divided period. The period in progress keeps the old length.
- R9: Written fields read back at their bit positions, all other bits and unmapped addresses read 0, and the control register changes only on a write to its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioTick | input | 1 | I/O reference tick enable |
| cpuTick | input | 1 | CPU reference tick enable |
| memTick | input | 1 | Memory reference tick enable |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address for read and write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data at regAddr |
| out0Pulse | output | 1 | Gated divided output 0 (one-cycle pulses) |
| out1Pulse | output | 1 | Gated divided output 1 (dual-output variant only) |

## Verification
The assertions check on every cycle that:
- the active divider settings change only in a cycle that follows a period end;
- both counters stay below their effective limits;
- every output pulse lines up with the counters restarting from zero;
- the stored registers move only on writes to their own addresses.

Only the bench scenarios can show the pulse rates. The bench counts pulses over windows that are whole multiples of the period, for each source code, for zero and maximum dividers, and for each gate pattern. It also shows that a period already in progress keeps its old length when a new divider is written, that fields which are absent in a variant are ignored, and that the inverted fabric gate works.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  parameter int DIV_W = 6;
  parameter int SEL_W = 2;
  parameter int DATA_W = 32;

  localparam int SEL_LSB = 4;
  localparam int DIV1_LSB = 8;
  localparam int DIV2_LSB = 20;
  localparam int GATE0_BIT = 0;
  localparam int GATE1_BIT = 1;
  localparam int CTRL_OFS = 0;
  localparam int GATE_OFS = CTRL_OFS + 8;

  typedef enum logic [SEL_W-1:0] {
    SRC_IO_A = 2'd0,
    SRC_IO_B = 2'd1,
    SRC_CPU  = 2'd2,
    SRC_MEM  = 2'd3
  } src_sel_e;

  typedef struct packed {
    src_sel_e          sel;
    logic [DIV_W-1:0]  div1;
    logic [DIV_W-1:0]  div2;
  } pcg_cfg_t;

  typedef struct packed {
    pcg_cfg_t pendCfg;
    logic     gate0;
    logic     gate1;
  } pcg_strobe_t;

  localparam pcg_cfg_t RESET_CFG = '{sel: SRC_IO_A, div1: DIV_W'(1), div2: DIV_W'(1)};

  function automatic logic [DIV_W-1:0] effDiv(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction
endpackage

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import pcg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter bit DUAL_OUT = 1'b1,
  parameter bit FABRIC_GATE = 1'b0,
  parameter bit TWO_STAGE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output pcg_strobe_t       ctlStb
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(GATE_OFS);
  localparam bit HAS_OUT1 = DUAL_OUT && !FABRIC_GATE;

  logic [SEL_W-1:0] selQ;
  logic [DIV_W-1:0] div1Q;
  logic [DIV_W-1:0] div2Q;
  logic             g0Q;
  logic             g1Q;
  logic             fabGateQ;
  logic             ctrlWr;
  logic             gateWr;
  logic             unusedWdata;

  assign ctrlWr = regWe && (regAddr == CTRL_ADDR);
  assign gateWr = regWe && (regAddr == GATE_ADDR) && FABRIC_GATE;
  assign unusedWdata = ^regWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ     <= RESET_CFG.sel;
      div1Q    <= RESET_CFG.div1;
      div2Q    <= RESET_CFG.div2;
      g0Q      <= 1'b0;
      g1Q      <= 1'b0;
      fabGateQ <= 1'b1;
    end else begin
      if (ctrlWr) begin
        selQ  <= regWdata[SEL_LSB +: SEL_W];
        div1Q <= regWdata[DIV1_LSB +: DIV_W];
        if (TWO_STAGE) div2Q <= regWdata[DIV2_LSB +: DIV_W];
        if (!FABRIC_GATE) g0Q <= regWdata[GATE0_BIT];
        if (HAS_OUT1) g1Q <= regWdata[GATE1_BIT];
      end
      if (gateWr) fabGateQ <= regWdata[GATE0_BIT];
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_ADDR) begin
      regRdata[SEL_LSB +: SEL_W]   = selQ;
      regRdata[DIV1_LSB +: DIV_W]  = div1Q;
      if (TWO_STAGE) regRdata[DIV2_LSB +: DIV_W] = div2Q;
      if (!FABRIC_GATE) regRdata[GATE0_BIT] = g0Q;
      if (HAS_OUT1) regRdata[GATE1_BIT] = g1Q;
    end else if (FABRIC_GATE && regAddr == GATE_ADDR) begin
      regRdata[GATE0_BIT] = fabGateQ;
    end
  end

  always_comb begin
    ctlStb.pendCfg.sel  = src_sel_e'(selQ);
    ctlStb.pendCfg.div1 = div1Q;
    ctlStb.pendCfg.div2 = TWO_STAGE ? div2Q : RESET_CFG.div2;
    ctlStb.gate0        = FABRIC_GATE ? !fabGateQ : g0Q;
    ctlStb.gate1        = HAS_OUT1 ? g1Q : 1'b0;
  end

  assert_ctrl_write_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({selQ, div1Q, div2Q, g0Q, g1Q}) |-> $past(regWe && regAddr == CTRL_ADDR))
    else $error("control register changed without a write");

  assert_fab_gate_write_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fabGateQ) |-> $past(regWe && regAddr == GATE_ADDR))
    else $error("gate register changed without a write");

  assert_absent_div2_R7: assert property (@(posedge clk) disable iff (!rstN)
    !TWO_STAGE |-> div2Q == RESET_CFG.div2)
    else $error("absent second divider was stored");
endmodule

// File: rtl/pcg_datapath.sv
module pcg_datapath
  import pcg_pkg::*;
#(
  parameter bit TWO_STAGE = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioTick,
  input  logic        cpuTick,
  input  logic        memTick,
  input  pcg_strobe_t ctlStb,
  output logic        out0Pulse,
  output logic        out1Pulse
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  pcg_cfg_t         actCfg;
  logic             srcTick;
  logic [DIV_W-1:0] cnt1;
  logic [DIV_W-1:0] cnt2;
  logic             stage1Wrap;
  logic             periodEnd;

  always_comb begin
    unique case (actCfg.sel)
      SRC_CPU: srcTick = cpuTick;
      SRC_MEM: srcTick = memTick;
      default: srcTick = ioTick;
    endcase
  end

  assign stage1Wrap = srcTick && (cnt1 == effDiv(actCfg.div1) - ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt1 <= '0;
    end else if (srcTick) begin
      cnt1 <= stage1Wrap ? '0 : cnt1 + ONE;
    end
  end

  generate
    if (TWO_STAGE) begin : gStage2
      assign periodEnd = stage1Wrap && (cnt2 == effDiv(actCfg.div2) - ONE);
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cnt2 <= '0;
        end else if (stage1Wrap) begin
          cnt2 <= periodEnd ? '0 : cnt2 + ONE;
        end
      end
      assert_cnt2_range_R4: assert property (@(posedge clk) disable iff (!rstN)
        cnt2 < effDiv(actCfg.div2))
        else $error("second counter beyond its limit");
    end else begin : gStage1Only
      logic unusedDiv2;
      assign periodEnd = stage1Wrap;
      assign cnt2 = '0;
      assign unusedDiv2 = ^actCfg.div2;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCfg    <= RESET_CFG;
      out0Pulse <= 1'b0;
      out1Pulse <= 1'b0;
    end else begin
      if (periodEnd) actCfg <= ctlStb.pendCfg;
      out0Pulse <= periodEnd && ctlStb.gate0;
      out1Pulse <= periodEnd && ctlStb.gate1;
    end
  end

  assert_cfg_at_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actCfg) |-> $past(periodEnd))
    else $error("active settings changed mid-period");

  assert_cnt1_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    cnt1 < effDiv(actCfg.div1))
    else $error("first counter beyond its limit");

  assert_pulse_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    (out0Pulse || out1Pulse) |-> (cnt1 == '0 && cnt2 == '0))
    else $error("output pulse not at period restart");
endmodule

// File: rtl/periph_clk_gen.sv
module periph_clk_gen
  import pcg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter bit DUAL_OUT = 1'b1,
  parameter bit FABRIC_GATE = 1'b0,
  parameter bit TWO_STAGE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioTick,
  input  logic              cpuTick,
  input  logic              memTick,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              out0Pulse,
  output logic              out1Pulse
);
  pcg_strobe_t ctlStb;

  pcg_ctrl #(
    .ADDR_W(ADDR_W), .DUAL_OUT(DUAL_OUT),
    .FABRIC_GATE(FABRIC_GATE), .TWO_STAGE(TWO_STAGE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ctlStb(ctlStb)
  );

  pcg_datapath #(.TWO_STAGE(TWO_STAGE)) uPath (
    .clk(clk), .rstN(rstN), .ioTick(ioTick), .cpuTick(cpuTick),
    .memTick(memTick), .ctlStb(ctlStb),
    .out0Pulse(out0Pulse), .out1Pulse(out1Pulse)
  );

  assert_no_out1_fabric_R6: assert property (@(posedge clk) disable iff (!rstN)
    (FABRIC_GATE || !DUAL_OUT) |-> !out1Pulse)
    else $error("output 1 active in single-output variant");
endmodule

// File: tb/tb_periph_clk_gen.sv
`timescale 1ns/1ps
module tb_periph_clk_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioTick = 1'b1, cpuTick = 1'b0, memTick = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdA, rdB;
  logic o0A, o1A, o0B, o1B;
  int nChecks = 0, nFail = 0, cyc = 0, phase = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    phase   <= phase + 1;
    cpuTick <= ((phase + 1) % 2) == 0;
    memTick <= ((phase + 1) % 3) == 0;
  end

  periph_clk_gen dut (
    .clk(clk), .rstN(rstN), .ioTick(ioTick), .cpuTick(cpuTick), .memTick(memTick),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdA),
    .out0Pulse(o0A), .out1Pulse(o1A));

  periph_clk_gen #(.DUAL_OUT(1'b0), .FABRIC_GATE(1'b1), .TWO_STAGE(1'b0)) dutFab (
    .clk(clk), .rstN(rstN), .ioTick(ioTick), .cpuTick(cpuTick), .memTick(memTick),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdB),
    .out0Pulse(o0B), .out1Pulse(o1B));

  typedef struct packed {
    logic [1:0]  sel;
    logic [5:0]  d1;
    logic [5:0]  d2;
    logic [1:0]  gates;
    logic [15:0] period;
  } vec_t;

  localparam int NVEC = 8;
  localparam int REPS = 6;
  localparam vec_t VECS [NVEC] = '{
    '{sel: 2'd0, d1: 6'd1,  d2: 6'd1, gates: 2'b01, period: 16'd1},
    '{sel: 2'd1, d1: 6'd3,  d2: 6'd1, gates: 2'b11, period: 16'd3},
    '{sel: 2'd2, d1: 6'd2,  d2: 6'd3, gates: 2'b10, period: 16'd12},
    '{sel: 2'd3, d1: 6'd4,  d2: 6'd2, gates: 2'b11, period: 16'd24},
    '{sel: 2'd0, d1: 6'd0,  d2: 6'd5, gates: 2'b01, period: 16'd5},
    '{sel: 2'd3, d1: 6'd0,  d2: 6'd0, gates: 2'b11, period: 16'd3},
    '{sel: 2'd2, d1: 6'd5,  d2: 6'd1, gates: 2'b00, period: 16'd10},
    '{sel: 2'd0, d1: 6'd63, d2: 6'd1, gates: 2'b01, period: 16'd63}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [31:0] ctrlWord(input logic [1:0] s, input logic [5:0] a,
                                            input logic [5:0] b, input logic [1:0] g);
    return (32'(b) << 20) | (32'(a) << 8) | (32'(s) << 4) | 32'(g);
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] dA, output logic [31:0] dB);
    regAddr = a; #1; dA = rdA; dB = rdB;
  endtask

  task automatic countPulses(input int win, output int c0, output int c1, output int cf);
    c0 = 0; c1 = 0; cf = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      c0 += int'(o0A); c1 += int'(o1A); cf += int'(o0B);
    end
  endtask

  task automatic waitPulse(output int at);
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!o0A && guard < 1000);
    at = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int c0, c1, cf, t0, t1, t2;
    logic [31:0] a, b;

    // R1 reset state
    doReset();
    busRead(4'd0, a, b);
    chk("R1 ctrl reset two-stage", int'(a), 32'h0010_0100);
    chk("R1 ctrl reset single-stage", int'(b), 32'h0000_0100);
    busRead(4'd8, a, b);
    chk("R1 fabric gate reset", int'(b), 1);
    countPulses(20, c0, c1, cf);
    chk("R1 out0 idle", c0, 0);
    chk("R1 out1 idle", c1, 0);
    chk("R1 fabric out idle", cf, 0);

    // R2 R3 R4 R5 vector table
    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      doReset();
      busWrite(4'd0, ctrlWord(v.sel, v.d1, v.d2, 2'b00));
      repeat (3) @(negedge clk);
      busWrite(4'd0, ctrlWord(v.sel, v.d1, v.d2, v.gates));
      repeat (3) @(negedge clk);
      countPulses(REPS * int'(v.period), c0, c1, cf);
      chk($sformatf("R2 R3 R4 R5 vec%0d out0", k), c0, v.gates[0] ? REPS : 0);
      chk($sformatf("R2 R3 R4 R5 vec%0d out1", k), c1, v.gates[1] ? REPS : 0);
    end

    // R9 readback and masking
    doReset();
    busWrite(4'd0, 32'h0FF3_3F33);
    busRead(4'd0, a, b);
    chk("R9 ctrl readback", int'(a), 32'h03F0_3F33);
    chk("R7 R6 fabric ctrl readback", int'(b), 32'h0000_3F30);
    busRead(4'd4, a, b);
    chk("R9 unmapped reads zero", int'(a), 0);

    // R6 R7 fabric gate and ignored second divider
    doReset();
    busWrite(4'd0, ctrlWord(2'd0, 6'd4, 6'd7, 2'b11));
    repeat (3) @(negedge clk);
    countPulses(24, c0, c1, cf);
    chk("R6 fabric gate set stops output", cf, 0);
    busWrite(4'd8, 32'h0);
    repeat (3) @(negedge clk);
    countPulses(24, c0, c1, cf);
    chk("R6 R7 fabric running period 4", cf, 6);
    busWrite(4'd8, 32'h1);
    repeat (2) @(negedge clk);
    countPulses(24, c0, c1, cf);
    chk("R6 fabric gate set again", cf, 0);

    // R8 change only at period boundary
    doReset();
    busWrite(4'd0, ctrlWord(2'd0, 6'd8, 6'd1, 2'b01));
    repeat (3) @(negedge clk);
    waitPulse(t0);
    busWrite(4'd0, ctrlWord(2'd0, 6'd2, 6'd1, 2'b01));
    waitPulse(t1);
    waitPulse(t2);
    chk("R8 old period completes", t1 - t0, 8);
    chk("R8 new period applies after", t2 - t1, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule